// File: doc/BRIEF.md
# SDRAM Bank State Legality Monitor

This block sits passively beside the command bus of a four-bank synchronous DRAM. It does not drive the bus. On every rising clock edge it samples chip select, RAS, CAS, WE, the bank address and address bit 10. It decodes the command and keeps a model of every bank: idle, open (row active) or precharging. On top of the bank models it keeps one device-wide mode for the auto-refresh and mode-register cycles. Each command is judged against that model and against minimum command spacings. The spacings are parameters counted in clock cycles.

The verdict appears combinationally in the same cycle as the command. `illegal_o` marks a command that the current state does not allow. `timing_err_o` marks a command that the state allows but that arrives too early. A reason code names the cause in both cases. A command that is flagged leaves the tracked state untouched, so one bad command does not corrupt the checks that follow. The decoded command and the state of every bank are also output, for use by a scoreboard or a trace.

A spacing of N cycles means that a command issued N clock edges after the earlier command is accepted, and one issued N-1 edges after it is flagged.

Top module: `sdr_bank_monitor`

## Requirements
- R1: The command code on `cmd_o` is decoded from the pins as follows. `cs_n`=1 gives 0 (deselect). With `cs_n`=0, the value of {`ras_n`,`cas_n`,`we_n`} gives: 111 → 1 (no-op), 110 → 2 (burst stop), 101 → 3 (read), 100 → 4 (write), 011 → 5 (activate), 010 → 6 (precharge), 001 → 7 (refresh), 000 → 8 (mode set).
- R2: After reset, every bank reports state 0 (idle) and every spacing counter is cleared. An activate, refresh or mode set in the first cycle after reset is therefore accepted.
- R3: An activate to an idle bank moves that bank to state 1 (open) from the next cycle. An activate to a bank that is already open is illegal, with reason 3.
- R4: A read or write to a bank that is not open is illegal, with reason 2. A read or write issued fewer than T_RCD cycles after the bank's activate is a timing error, with reason 5.
- R5: While some other bank is open, an activate issued fewer than T_RRD cycles after the previous activate is a timing error, with reason 6.
- R6: A precharge to an open bank raises a timing error in two cases: reason 7 if it comes fewer than T_RAS cycles after the bank's activate, and reason 8 if it comes fewer than T_RWL cycles after the bank's last write. An accepted precharge puts the bank in state 2 (precharging). The bank reports state 0 from T_RP cycles after the precharge. An activate to a bank that is still precharging is a timing error, with reason 9.
- R7: A precharge with `a10`=1 applies to every open bank, and the spacing checks cover all of those banks. A precharge to an idle bank is accepted and changes nothing.
- R8: A refresh or mode set is illegal with reason 4 unless all banks report idle. An accepted refresh makes every bank report state 3 for T_RC cycles. An accepted mode set makes every bank report state 4 for T_MRD cycles. During either window, any command other than deselect, no-op or burst stop is illegal, with reason 1.
- R9: Deselect, no-op and burst stop are never flagged and never change any bank state.
- R10: `illegal_o` and `timing_err_o` are never high together. `reason_o` is 0 when both are low. The verdict appears in the same cycle as the command.
- R11: A command that raises `illegal_o` or `timing_err_o` changes no bank state.
- R12: A read or write accepted with `a10`=1 (auto-precharge) puts the bank in state 2 from the next cycle. The bank returns to state 0 T_RP cycles after that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, the same as the memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW (2) | Bank address |
| a10 | input | 1 | Address bit 10: all-banks on precharge, auto-precharge on read/write |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_state_o | output | 3*NB (12) | Per-bank state, bank i in bits [3i+2:3i] |
| illegal_o | output | 1 | Command not allowed in the current state |
| timing_err_o | output | 1 | Command allowed but issued inside a spacing window |
| reason_o | output | 4 | Cause of the flag, 0 when no flag is raised |

## Verification
The bench places each command on both sides of its window boundary: one cycle early and exactly on time. This applies to T_RCD, T_RRD, T_RAS, T_RWL, T_RP, T_RC and T_MRD. An off-by-one error in a counter load or in the release of a state would then flag a legal command or accept an early one.

When a precharge is both inside T_RAS and inside the post-write window, the bench expects the T_RAS reason (7). It also checks that an early precharge-all leaves all banks open. A design that applied a rejected command to the state would show a bank precharging in the next cycle.

A refresh is tried while one bank is still precharging. A design that looked only at the registered state, and not at the expired precharge counter, would accept it too soon, or hold off the refresh that follows too long.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPEN    = 3'd1,
    BK_PRECH   = 3'd2,
    BK_REFRESH = 3'd3,
    BK_MODESET = 3'd4
  } bank_st_e;

  typedef enum logic [1:0] {
    GM_NORMAL  = 2'd0,
    GM_REFRESH = 2'd1,
    GM_MODESET = 2'd2
  } gmode_e;

  typedef enum logic [3:0] {
    RS_NONE         = 4'd0,
    RS_BUSY         = 4'd1,
    RS_NOT_OPEN     = 4'd2,
    RS_ALREADY_OPEN = 4'd3,
    RS_NOT_ALL_IDLE = 4'd4,
    RS_TRCD         = 4'd5,
    RS_TRRD         = 4'd6,
    RS_TRAS         = 4'd7,
    RS_TRWL         = 4'd8,
    RS_TRP          = 4'd9
  } reason_e;

  // Counter load value for a spacing of t cycles: the command t edges later sees zero.
  function automatic int unsigned cyc_load(input int unsigned t);
    return (t > 0) ? t - 1 : 0;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_n) begin
      cmd_o = CMD_DESL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd_o = CMD_NOP;
        3'b110:  cmd_o = CMD_BST;
        3'b101:  cmd_o = CMD_READ;
        3'b100:  cmd_o = CMD_WRITE;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdr_dcount.sv
module sdr_dcount #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign busy_o = (cnt_q != '0);
  assign cnt_en = load_i | busy_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (busy_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: a running window shrinks by exactly one per cycle unless reloaded
  a_r2_window_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_mon_pkg::*;
#(
  parameter int          CW    = 4,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RWL = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_i,
  input  logic     pre_i,
  input  logic     wr_i,
  output bank_st_e st_o,
  output logic     rcd_busy_o,
  output logic     ras_busy_o,
  output logic     rwl_busy_o
);

  localparam int NCNT = 4;
  localparam int unsigned TV [NCNT] = '{T_RCD, T_RAS, T_RP, T_RWL};

  bank_st_e        st_q;
  bank_st_e        st_d;
  logic            st_en;
  logic [NCNT-1:0] ld;
  logic [NCNT-1:0] bz;

  // counter slots: 0 row-to-column, 1 row-active minimum, 2 precharge, 3 post-write
  assign ld = {wr_i, pre_i, act_i, act_i};

  for (genvar i = 0; i < NCNT; i++) begin : g_win
    sdr_dcount #(.CW(CW)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld[i]),
      .load_val_i (CW'(cyc_load(TV[i]))),
      .busy_o     (bz[i])
    );
  end

  assign rcd_busy_o = bz[0];
  assign ras_busy_o = bz[1];
  assign rwl_busy_o = bz[3];

  // a finished precharge already counts as idle in the cycle its window closes
  assign st_o = (st_q == BK_PRECH && !bz[2]) ? BK_IDLE : st_q;

  always_comb begin
    st_d = st_o;
    if (act_i)      st_d = BK_OPEN;
    else if (pre_i) st_d = BK_PRECH;
  end

  assign st_en = act_i | pre_i | (st_o != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= BK_IDLE;
    else if (st_en) st_q <= st_d;
  end

  // R3: an accepted activate opens the bank on the next cycle
  a_r3_open_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (st_q == BK_OPEN));

  // R6: no activate is ever accepted while the precharge window runs
  a_r6_no_act_in_trp: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_PRECH && bz[2]) |-> !act_i);

  // R12: an accepted precharge or auto-precharge always lands in precharging
  a_r12_prech_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !act_i) |=> (st_q == BK_PRECH));

endmodule

// File: rtl/sdr_global_track.sv
module sdr_global_track
  import sdr_mon_pkg::*;
#(
  parameter int          CW    = 4,
  parameter int unsigned T_RC  = 5,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RRD = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ref_i,
  input  logic   mrs_i,
  input  logic   act_i,
  output gmode_e mode_o,
  output logic   rrd_busy_o
);

  gmode_e        mode_q;
  gmode_e        mode_d;
  logic          mode_en;
  logic          cyc_busy;
  logic [CW-1:0] cyc_val;

  assign cyc_val = ref_i ? CW'(cyc_load(T_RC)) : CW'(cyc_load(T_MRD));

  sdr_dcount #(.CW(CW)) u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ref_i | mrs_i),
    .load_val_i (cyc_val),
    .busy_o     (cyc_busy)
  );

  sdr_dcount #(.CW(CW)) u_rrd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (act_i),
    .load_val_i (CW'(cyc_load(T_RRD))),
    .busy_o     (rrd_busy_o)
  );

  assign mode_o = (mode_q != GM_NORMAL && !cyc_busy) ? GM_NORMAL : mode_q;

  always_comb begin
    mode_d = mode_o;
    if (ref_i)      mode_d = GM_REFRESH;
    else if (mrs_i) mode_d = GM_MODESET;
  end

  assign mode_en = ref_i | mrs_i | (mode_o != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= GM_NORMAL;
    else if (mode_en) mode_q <= mode_d;
  end

  // R8: nothing that changes state is accepted during refresh or mode set
  a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != GM_NORMAL) |-> !(ref_i || mrs_i || act_i));

endmodule

// File: rtl/sdr_bank_monitor.sv
module sdr_bank_monitor
  import sdr_mon_pkg::*;
#(
  parameter int          NB    = 4,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_RC  = 5,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RWL = 2,
  localparam int         BAW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BAW-1:0]  ba,
  input  logic            a10,
  output logic [3:0]      cmd_o,
  output logic [3*NB-1:0] bank_state_o,
  output logic            illegal_o,
  output logic            timing_err_o,
  output logic [3:0]      reason_o
);

  localparam int unsigned TMAX = max2(max2(max2(T_RCD, T_RAS), max2(T_RP, T_RRD)),
                                      max2(max2(T_RC, T_MRD), T_RWL));
  localparam int CW = $clog2(TMAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  cmd_e     cmd;
  gmode_e   gmode;
  logic     gbusy;
  logic     rrd_bz;
  bank_st_e bk_st [NB];
  logic [NB-1:0] bk_open, bk_idle, rcd_bz, ras_bz, rwl_bz;
  logic [NB-1:0] act_ev, pre_ev, wr_ev;
  logic [NB-1:0] tgt, pre_mask, pre_hit;
  logic          ref_ev, mrs_ev;
  logic          ill, tim;
  reason_e       rsn;

  sdr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd_o (cmd)
  );

  sdr_global_track #(.CW(CW), .T_RC(T_RC), .T_MRD(T_MRD), .T_RRD(T_RRD)) u_glob (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ref_i      (ref_ev),
    .mrs_i      (mrs_ev),
    .act_i      (|act_ev),
    .mode_o     (gmode),
    .rrd_busy_o (rrd_bz)
  );

  assign gbusy = (gmode != GM_NORMAL);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    sdr_bank_track #(.CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RWL(T_RWL)) u_bank (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .act_i      (act_ev[i]),
      .pre_i      (pre_ev[i]),
      .wr_i       (wr_ev[i]),
      .st_o       (bk_st[i]),
      .rcd_busy_o (rcd_bz[i]),
      .ras_busy_o (ras_bz[i]),
      .rwl_busy_o (rwl_bz[i])
    );
    assign bk_open[i] = (bk_st[i] == BK_OPEN);
    assign bk_idle[i] = (bk_st[i] == BK_IDLE);
    assign bank_state_o[3*i +: 3] = (gmode == GM_REFRESH) ? BK_REFRESH :
                                    (gmode == GM_MODESET) ? BK_MODESET : bk_st[i];
  end

  assign tgt      = NB'(1) << ba;
  assign pre_mask = a10 ? '1 : tgt;
  assign pre_hit  = pre_mask & bk_open;

  // verdict: state legality first, then spacing windows
  always_comb begin
    ill    = 1'b0;
    tim    = 1'b0;
    rsn    = RS_NONE;
    act_ev = '0;
    pre_ev = '0;
    wr_ev  = '0;
    ref_ev = 1'b0;
    mrs_ev = 1'b0;
    case (cmd)
      CMD_READ, CMD_WRITE: begin
        if (gbusy)                begin ill = 1'b1; rsn = RS_BUSY;     end
        else if (!bk_open[ba])    begin ill = 1'b1; rsn = RS_NOT_OPEN; end
        else if (rcd_bz[ba])      begin tim = 1'b1; rsn = RS_TRCD;     end
        else begin
          if (cmd == CMD_WRITE) wr_ev = tgt;
          if (a10)              pre_ev = tgt;
        end
      end
      CMD_ACT: begin
        if (gbusy)                        begin ill = 1'b1; rsn = RS_BUSY;         end
        else if (bk_open[ba])             begin ill = 1'b1; rsn = RS_ALREADY_OPEN; end
        else if (bk_st[ba] == BK_PRECH)   begin tim = 1'b1; rsn = RS_TRP;          end
        else if (rrd_bz && |(bk_open & ~tgt)) begin tim = 1'b1; rsn = RS_TRRD;     end
        else act_ev = tgt;
      end
      CMD_PRE: begin
        if (gbusy)                    begin ill = 1'b1; rsn = RS_BUSY; end
        else if (|(pre_hit & ras_bz)) begin tim = 1'b1; rsn = RS_TRAS; end
        else if (|(pre_hit & rwl_bz)) begin tim = 1'b1; rsn = RS_TRWL; end
        else pre_ev = pre_hit;
      end
      CMD_REF, CMD_MRS: begin
        if (gbusy)           begin ill = 1'b1; rsn = RS_BUSY;         end
        else if (!(&bk_idle)) begin ill = 1'b1; rsn = RS_NOT_ALL_IDLE; end
        else begin
          ref_ev = (cmd == CMD_REF);
          mrs_ev = (cmd == CMD_MRS);
        end
      end
      default: ;
    endcase
  end

  assign cmd_o        = cmd;
  assign illegal_o    = ill;
  assign timing_err_o = tim;
  assign reason_o     = rsn;

  // R10: at most one flag per command
  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({illegal_o, timing_err_o}));

  // R10: reason is zero whenever no flag is raised
  a_r10_quiet_reason: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!illegal_o && !timing_err_o) |-> (reason_o == 4'd0));

  // R11: a flagged command reaches no tracker
  a_r11_fault_inert: assert property (@(posedge clk) disable iff (!rst_s_n)
    (illegal_o || timing_err_o) |-> (act_ev == '0 && pre_ev == '0 && wr_ev == '0 && !ref_ev && !mrs_ev));

  // R4: an accepted column command always finds its bank open and past its row-to-column window
  a_r4_column_needs_open: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((cmd_o == CMD_READ || cmd_o == CMD_WRITE) && !illegal_o && !timing_err_o)
      |-> (bk_open[ba] && !rcd_bz[ba]));

  // R9: idle-type commands are never flagged
  a_r9_filler_clean: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_o == CMD_DESL || cmd_o == CMD_NOP || cmd_o == CMD_BST) |-> (!illegal_o && !timing_err_o));

endmodule

// File: tb/sdr_bank_monitor_test.sv
module sdr_bank_monitor_test;

  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RRD = 2, T_RC = 5, T_MRD = 2, T_RWL = 2;

  // command codes (R1)
  localparam int K_DESL = 0, K_NOP = 1, K_BST = 2, K_RD = 3, K_WR = 4,
                 K_ACT = 5, K_PRE = 6, K_REF = 7, K_MRS = 8;
  // bank states (R3, R6, R8)
  localparam int S_IDLE = 0, S_OPEN = 1, S_PRECH = 2, S_REF = 3, S_MODE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic        a10;
  logic [3:0]  cmd_o;
  logic [11:0] bank_state_o;
  logic        illegal_o, timing_err_o;
  logic [3:0]  reason_o;

  int vecs = 0;
  int miss = 0;

  always #2 clk = ~clk;

  sdr_bank_monitor #(
    .NB(4), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD),
    .T_RC(T_RC), .T_MRD(T_MRD), .T_RWL(T_RWL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
    .illegal_o(illegal_o), .timing_err_o(timing_err_o), .reason_o(reason_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input int ill, input int tim, input int rsn);
    chk({tag, " illegal"}, int'(illegal_o), ill);
    chk({tag, " timing"}, int'(timing_err_o), tim);
    chk({tag, " reason"}, int'(reason_o), rsn);
  endtask

  task automatic chk_bank(input string tag, input int b, input int st);
    chk(tag, int'(bank_state_o[b*3 +: 3]), st);
  endtask

  // drive a command mid-cycle; outputs are stable 1 ns later, before the committing edge
  task automatic issue(input int c, input int b, input bit a);
    @(negedge clk);
    cs_n = 1'b0;
    case (c)
      K_DESL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
      K_NOP:  {ras_n, cas_n, we_n} = 3'b111;
      K_BST:  {ras_n, cas_n, we_n} = 3'b110;
      K_RD:   {ras_n, cas_n, we_n} = 3'b101;
      K_WR:   {ras_n, cas_n, we_n} = 3'b100;
      K_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      K_PRE:  {ras_n, cas_n, we_n} = 3'b010;
      K_REF:  {ras_n, cas_n, we_n} = 3'b001;
      default: {ras_n, cas_n, we_n} = 3'b000;
    endcase
    ba  = 2'(b);
    a10 = a;
    #1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 1'b0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = 2'd0; a10 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    for (int b = 0; b < 4; b++) chk_bank("R2 reset bank idle", b, S_IDLE);
    chk_flags("R2 reset flags", 0, 0, 0);
    chk("R1 deselect code", int'(cmd_o), K_DESL);
  endtask

  task automatic t_decode_idle;
    do_reset();
    issue(K_NOP, 0, 1'b0);  chk("R1 nop code", int'(cmd_o), K_NOP);  chk_flags("R9 nop", 0, 0, 0);
    issue(K_BST, 0, 1'b0);  chk("R1 bst code", int'(cmd_o), K_BST);  chk_flags("R9 bst", 0, 0, 0);
    issue(K_RD, 0, 1'b0);   chk("R1 read code", int'(cmd_o), K_RD);  chk_flags("R4 read idle bank", 1, 0, 2);
    issue(K_WR, 2, 1'b0);   chk("R1 write code", int'(cmd_o), K_WR); chk_flags("R4 write idle bank", 1, 0, 2);
    issue(K_PRE, 1, 1'b0);  chk("R1 pre code", int'(cmd_o), K_PRE);  chk_flags("R7 pre idle bank", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R7 idle bank after pre", 1, S_IDLE);
  endtask

  task automatic t_act_rcd;
    do_reset();
    issue(K_ACT, 0, 1'b0);  chk("R1 act code", int'(cmd_o), K_ACT); chk_flags("R2 act right after reset", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R3 bank opened", 0, S_OPEN); chk_bank("R3 other bank idle", 1, S_IDLE);
    issue(K_RD, 0, 1'b0);   chk_flags("R4 read one cycle early", 0, 1, 5);
    issue(K_RD, 0, 1'b0);   chk_flags("R4 read on time", 0, 0, 0);
    issue(K_ACT, 0, 1'b0);  chk_flags("R3 reactivate open bank", 1, 0, 3);
    issue(K_RD, 1, 1'b0);   chk_flags("R4 read closed bank", 1, 0, 2);
    chk_bank("R11 bank still open", 0, S_OPEN);
  endtask

  task automatic t_rrd;
    do_reset();
    issue(K_ACT, 0, 1'b0);  chk_flags("R5 first act", 0, 0, 0);
    issue(K_ACT, 1, 1'b0);  chk_flags("R5 second act early", 0, 1, 6);
    issue(K_NOP, 0, 1'b0);  chk_bank("R11 early act ignored", 1, S_IDLE);
    issue(K_ACT, 1, 1'b0);  chk_flags("R5 second act later", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R5 second bank open", 1, S_OPEN);
  endtask

  task automatic t_pre_windows;
    do_reset();
    issue(K_ACT, 0, 1'b0);
    nops(2);
    issue(K_WR, 0, 1'b0);   chk_flags("R4 write on time", 0, 0, 0);
    issue(K_PRE, 0, 1'b0);  chk_flags("R6 pre inside row-active window", 0, 1, 7);
    issue(K_WR, 0, 1'b0);   chk_flags("R6 second write", 0, 0, 0);
    issue(K_PRE, 0, 1'b0);  chk_flags("R6 pre inside post-write window", 0, 1, 8);
    chk_bank("R11 bank open after refused pre", 0, S_OPEN);
    issue(K_PRE, 0, 1'b0);  chk_flags("R6 pre on time", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R6 bank precharging", 0, S_PRECH);
    issue(K_ACT, 0, 1'b0);  chk_flags("R6 act during precharge", 0, 1, 9);
    chk_bank("R6 still precharging", 0, S_PRECH);
    issue(K_ACT, 0, 1'b0);  chk_bank("R6 idle after precharge window", 0, S_IDLE);
    chk_flags("R6 act after precharge", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R6 reopened", 0, S_OPEN);
  endtask

  task automatic t_pre_all;
    do_reset();
    issue(K_ACT, 0, 1'b0);
    issue(K_NOP, 0, 1'b0);
    issue(K_ACT, 3, 1'b0);  chk_flags("R5 act after spacing", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);
    issue(K_BST, 0, 1'b0);  chk_flags("R9 bst while open", 0, 0, 0);
    issue(K_DESL, 0, 1'b0); chk_bank("R9 bst left bank open", 3, S_OPEN);
    issue(K_NOP, 0, 1'b0);
    issue(K_PRE, 1, 1'b1);  chk_flags("R7 pre-all early for one bank", 0, 1, 7);
    issue(K_PRE, 2, 1'b1);  chk_bank("R11 bank0 still open", 0, S_OPEN);
    chk_flags("R7 pre-all on time", 0, 0, 0);
    issue(K_PRE, 1, 1'b0);  chk_flags("R7 pre idle bank", 0, 0, 0);
    chk_bank("R7 bank0 precharging", 0, S_PRECH);
    chk_bank("R7 bank3 precharging", 3, S_PRECH);
    chk_bank("R7 bank2 untouched", 2, S_IDLE);
    issue(K_NOP, 0, 1'b0);  chk_bank("R7 bank1 untouched", 1, S_IDLE);
  endtask

  task automatic t_refresh_mode;
    do_reset();
    issue(K_ACT, 1, 1'b0);
    issue(K_REF, 0, 1'b0);  chk("R1 ref code", int'(cmd_o), K_REF); chk_flags("R8 ref with open bank", 1, 0, 4);
    issue(K_NOP, 0, 1'b0);  chk_bank("R11 open after refused ref", 1, S_OPEN);
    nops(3);
    issue(K_PRE, 1, 1'b0);  chk_flags("R6 pre after row-active window", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);
    issue(K_REF, 0, 1'b0);  chk_flags("R8 ref while precharging", 1, 0, 4);
    issue(K_REF, 0, 1'b0);  chk_flags("R8 ref all idle", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R8 refresh shown bank0", 0, S_REF); chk_bank("R8 refresh shown bank3", 3, S_REF);
    issue(K_ACT, 0, 1'b0);  chk_flags("R8 act during refresh", 1, 0, 1);
    issue(K_DESL, 0, 1'b0); chk_flags("R9 deselect during refresh", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R8 refresh last cycle", 2, S_REF);
    issue(K_MRS, 0, 1'b0);  chk("R1 mrs code", int'(cmd_o), K_MRS); chk_flags("R8 mode set after refresh", 0, 0, 0);
    chk_bank("R8 refresh over", 1, S_IDLE);
    issue(K_RD, 0, 1'b0);   chk_flags("R8 read during mode set", 1, 0, 1);
    chk_bank("R8 mode set shown", 0, S_MODE);
    issue(K_NOP, 0, 1'b0);  chk_bank("R8 mode set over", 0, S_IDLE);
  endtask

  task automatic t_auto_pre;
    do_reset();
    issue(K_ACT, 2, 1'b0);
    nops(2);
    issue(K_RD, 2, 1'b1);   chk_flags("R12 read with auto-precharge", 0, 0, 0);
    issue(K_NOP, 0, 1'b0);  chk_bank("R12 precharging next cycle", 2, S_PRECH);
    issue(K_NOP, 0, 1'b0);  chk_bank("R12 precharge still running", 2, S_PRECH);
    issue(K_NOP, 0, 1'b0);  chk_bank("R12 idle after window", 2, S_IDLE);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
    t_decode_idle();
    t_act_rcd();
    t_rrd();
    t_pre_windows();
    t_pre_all();
    t_refresh_mode();
    t_auto_pre();
    report();
    $finish;
  end

endmodule